// File: doc/BRIEF.md
# Two-Wire Bus Target Byte Front End

This block is the bit-level target side of a two-wire serial bus. It runs on a fast system clock and oversamples the clock line and the data line, which are first passed through a two-stage synchronizer. From the synchronized lines it decodes start and stop conditions. It shifts bytes in and out most significant bit first, answers its own fixed 7-bit address, and drives the ninth-pulse acknowledge. The data output is open-drain in meaning: 0 pulls the line low and 1 releases it.

On the user side, each received write byte appears on `rx_byte` together with a one-cycle `rx_valid` strobe. For reads, a transmit byte is taken from `tx_byte` in the cycle where `tx_load` pulses. A storage back end raises `busy_i` while an internal write is in progress. As long as `busy_i` is high the block sends no acknowledge of any kind, so a controller can poll the address until the target answers again.

Top module: `i2c_tgt_front`

## Requirements
- R1: A start condition is a falling data line while the clock line is high. It begins reception of a new address byte from any state, with the data output released.
- R2: A stop condition is a rising data line while the clock line is high. It returns the block to idle with the data output released, and no bus activity is acted on until the next start.
- R3: The first byte after a start carries the 7-bit address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). The byte is sampled on rising clock edges, most significant bit first. A matching address is acknowledged. A mismatch produces no acknowledge and no `rx_valid` until the next start or stop.
- R4: In a write, each data byte is sampled on rising clock edges, most significant bit first. It appears on `rx_byte` with a one-cycle `rx_valid`, and it is acknowledged by holding the data output low over the whole ninth clock pulse.
- R5: If `busy_i` is high when a byte ends, the block gives no acknowledge, whether the byte is an address or data, and raises no `rx_valid`. It then ignores the bus until the next start or stop.
- R6: In a read, `tx_byte` is captured with a one-cycle `tx_load` after the address acknowledge and after every controller acknowledge. It is shifted out most significant bit first. The data output changes only while the synchronized clock line is low.
- R7: A not-acknowledge (line high on the ninth pulse) from the controller after a read byte ends the read. The data output then stays released and no further `tx_load` occurs until the next start or stop.
- R8: Out of reset the data output is released and `rx_valid` and `tx_load` are low. The output is released whenever the block is neither sending a 0 data bit nor an acknowledge.
- R9: The controller sets the byte count. Any number of data bytes may follow one address, and each byte is handled the same way.
- R10: A start that arrives in the middle of a byte (a repeated start) discards the partial byte and treats the next byte as a new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad (asynchronous) |
| sda_i | input | 1 | Bus data line as seen at the pad (asynchronous) |
| sda_o | output | 1 | Data line drive: 0 pulls low, 1 releases |
| busy_i | input | 1 | Back end busy; withholds every acknowledge |
| rx_byte | output | 8 | Last received write data byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is new |
| tx_byte | input | 8 | Byte to send in a read |
| tx_load | output | 1 | One-cycle strobe when `tx_byte` is captured |

## Verification
A wrong bit counter or wrong state shows up on the bus within one byte. The acknowledge either falls on the wrong pulse, is missing, or appears where it should be absent, and a read byte comes back shifted. If stop or start decoding is broken, the block either never leaves its ignore state or keeps driving. Either fault is visible within one bit period as a data line held low, or as a lost `rx_valid` or `tx_load` strobe. Each transaction the bench runs therefore checks the acknowledge bit, the strobe counts and the byte values right at the pulse where they are due.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    // Phases of the target front end.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_ADDR,   // shifting in the address byte
        ST_ACK,    // holding the line low for the ninth pulse
        ST_WR,     // shifting in a write data byte
        ST_RD,     // shifting out a read data byte
        ST_RDACK,  // sampling the controller acknowledge
        ST_SKIP    // not addressed or refused: wait for start or stop
    } tgt_st_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);

    // Every stage resets to the idle bus level (high).
    logic [LINES-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '1;
                else        stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '1;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_rise = scl_s & ~prev_q.scl;
    assign scl_fall = ~scl_s & prev_q.scl;
    // Data edges while the clock line stays high are bus conditions.
    assign start_p  = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_p   = scl_s & prev_q.scl & ~prev_q.sda & sda_s;

endmodule

// File: rtl/i2c_tgt_front.sv
module i2c_tgt_front #(
    parameter int   BYTE_W   = 8,
    parameter int   SYNC_LEN = 2,
    parameter logic [BYTE_W-2:0] TGT_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    input  logic              busy_i,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_load
);
    import i2c_tgt_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] BITS = CNT_W'(BYTE_W);

    typedef struct packed {
        tgt_st_e           st;
        logic [CNT_W-1:0]  cnt;   // rising clock edges seen in this byte
        logic [BYTE_W-1:0] sh;    // shift register, in or out
        logic              rd;    // addressed for a read
        logic              nak;   // controller left its ack slot high
        logic              sda;   // registered line drive
        logic              rxv;
        logic              txl;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st: ST_IDLE, cnt: '0, sh: '0, rd: 1'b0, nak: 1'b0,
        sda: 1'b1, rxv: 1'b0, txl: 1'b0
    };

    logic [1:0] raw_lines, sync_lines;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_p, stop_p;
    fsm_t       cur_q, nxt_d;
    tgt_st_e    cur_st;
    logic       cnt_zero;

    assign raw_lines = {scl_i, sda_i};

    i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    i2c_tgt_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.rxv = 1'b0;
        nxt_d.txl = 1'b0;
        if (stop_p) begin
            nxt_d.st  = ST_IDLE;
            nxt_d.cnt = '0;
            nxt_d.sda = 1'b1;
        end else if (start_p) begin
            nxt_d.st  = ST_ADDR;
            nxt_d.cnt = '0;
            nxt_d.sda = 1'b1;
            nxt_d.rd  = 1'b0;
        end else begin
            unique case (cur_q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise && cur_q.cnt != BITS) begin
                        nxt_d.sh  = {cur_q.sh[BYTE_W-2:0], sda_s};
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end else if (scl_fall && cur_q.cnt == BITS) begin
                        if (busy_i) begin
                            nxt_d.st = ST_SKIP;
                        end else if (cur_q.st == ST_ADDR) begin
                            if (cur_q.sh[BYTE_W-1:1] == TGT_ADDR) begin
                                nxt_d.st  = ST_ACK;
                                nxt_d.sda = 1'b0;
                                nxt_d.rd  = cur_q.sh[0];
                            end else begin
                                nxt_d.st = ST_SKIP;
                            end
                        end else begin
                            nxt_d.st  = ST_ACK;
                            nxt_d.sda = 1'b0;
                            nxt_d.rxv = 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        nxt_d.cnt = '0;
                        if (cur_q.rd) begin
                            nxt_d.st  = ST_RD;
                            nxt_d.sh  = tx_byte;
                            nxt_d.sda = tx_byte[BYTE_W-1];
                            nxt_d.txl = 1'b1;
                        end else begin
                            nxt_d.st  = ST_WR;
                            nxt_d.sda = 1'b1;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cur_q.cnt == BITS) begin
                            nxt_d.st  = ST_RDACK;
                            nxt_d.cnt = '0;
                            nxt_d.sda = 1'b1;
                        end else begin
                            nxt_d.sh  = {cur_q.sh[BYTE_W-2:0], 1'b0};
                            nxt_d.sda = cur_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        nxt_d.nak = sda_s;
                    end else if (scl_fall) begin
                        if (!cur_q.nak) begin
                            nxt_d.st  = ST_RD;
                            nxt_d.sh  = tx_byte;
                            nxt_d.sda = tx_byte[BYTE_W-1];
                            nxt_d.txl = 1'b1;
                        end else begin
                            nxt_d.st  = ST_SKIP;
                            nxt_d.sda = 1'b1;
                        end
                    end
                end
                default: begin
                    nxt_d.sda = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= FSM_RST;
        else        cur_q <= nxt_d;
    end

    assign sda_o    = cur_q.sda;
    assign rx_byte  = cur_q.sh;
    assign rx_valid = cur_q.rxv;
    assign tx_load  = cur_q.txl;
    assign cur_st   = cur_q.st;
    assign cnt_zero = (cur_q.cnt == '0);

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy_i,
    input logic                  sda_o,
    input logic                  rx_valid,
    input logic                  scl_s,
    input logic                  start_p,
    input logic                  stop_p,
    input logic                  cnt_zero,
    input i2c_tgt_pkg::tgt_st_e  cur_st
);
    import i2c_tgt_pkg::*;

    // R1: a start always leads to a fresh address byte with the line released
    a_r1_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_p && !stop_p |=> (cur_st == ST_ADDR) && cnt_zero && sda_o);

    // R2: a stop always leads to idle with the line released
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (cur_st == ST_IDLE) && sda_o);

    // R5: an acknowledge is never entered while the back end was busy
    a_r5_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_ACK) && ($past(cur_st) != ST_ACK) |-> !$past(busy_i));

    // R4: the receive strobe lasts a single cycle
    a_r4_rxv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: the drive changes only while the synchronized clock line is low
    a_r6_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_o) |-> !$past(scl_s));

    // R8: idle and ignore phases never pull the line
    a_r8_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_IDLE || cur_st == ST_SKIP) |-> sda_o);

endmodule

bind i2c_tgt_front i2c_tgt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy_i),
    .sda_o    (sda_o),
    .rx_valid (rx_valid),
    .scl_s    (scl_s),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .cnt_zero (cnt_zero),
    .cur_st   (cur_st)
);

// File: tb/test_i2c_tgt_front.sv
`timescale 1ns/1ps
module test_i2c_tgt_front;

    localparam int Q = 16;  // clocks per quarter bit period

    typedef struct packed {
        logic [6:0] a;
        logic       rw;
        logic [7:0] d;
        logic       bz;
        logic       ack;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{7'h50, 1'b0, 8'hA5, 1'b0, 1'b1},
        '{7'h50, 1'b1, 8'h3C, 1'b0, 1'b1},
        '{7'h51, 1'b0, 8'hFF, 1'b0, 1'b0},
        '{7'h50, 1'b0, 8'h00, 1'b1, 1'b0},
        '{7'h50, 1'b1, 8'h81, 1'b1, 1'b0},
        '{7'h28, 1'b0, 8'hA0, 1'b0, 1'b0},
        '{7'h50, 1'b0, 8'h7E, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_c = 1'b1;
    logic       busy = 1'b0;
    logic [7:0] txb = 8'h00;
    logic       sda_o, rx_valid, tx_load;
    logic [7:0] rx_byte;
    wire        sda_bus = sda_c & sda_o;

    int errors = 0;
    int checks = 0;
    int rx_n = 0;
    int tx_n = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_tgt_front i_i2c_tgt_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sda_o    (sda_o),
        .busy_i   (busy),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .tx_byte  (txb),
        .tx_load  (tx_load)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_n    <= rx_n + 1;
            rx_last <= rx_byte;
        end
        if (rst_n && tx_load) tx_n <= tx_n + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_c = 1'b1; wq();
        scl = 1'b1;   wq();
        sda_c = 1'b0; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        sda_c = 1'b0; wq();
        scl = 1'b1;   wq();
        sda_c = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_c = b; wq();
        scl = 1'b1; wq();
        r = sda_bus; wq();
        scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
        clk_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic r;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r);
            v = {v[6:0], r};
        end
        clk_bit(~give_ack, r);
    endtask

    initial begin
        logic       ak;
        logic       r;
        logic [7:0] v;
        int         rx0, tx0;

        repeat (5) @(negedge clk);
        // R8: reset state
        chk(sda_o == 1'b1, "R8 reset sda_o", sda_o, 1);
        chk(rx_valid == 1'b0 && tx_load == 1'b0, "R8 reset strobes", {rx_valid, tx_load}, 0);
        rst_n = 1'b1;
        wq();

        // Vector loop: R3 address, R4 write, R5 busy, R6 read
        for (int k = 0; k < NV; k++) begin
            busy = VECS[k].bz;
            txb  = VECS[k].d;
            rx0  = rx_n;
            bus_start();
            send_byte({VECS[k].a, VECS[k].rw}, ak);
            chk(ak == VECS[k].ack, "R3/R5 address ack", ak, VECS[k].ack);
            if (VECS[k].rw) begin
                recv_byte(1'b0, v);
                if (VECS[k].ack)
                    chk(v == VECS[k].d, "R6 read byte", v, VECS[k].d);
                else
                    chk(v == 8'hFF, "R3/R5 unaddressed read released", v, 8'hFF);
            end else begin
                send_byte(VECS[k].d, ak);
                chk(ak == VECS[k].ack, "R4/R5 data ack", ak, VECS[k].ack);
                chk(rx_n == rx0 + (VECS[k].ack ? 1 : 0), "R4/R3 rx_valid count", rx_n - rx0, VECS[k].ack);
                if (VECS[k].ack)
                    chk(rx_last == VECS[k].d, "R4 rx_byte", rx_last, VECS[k].d);
            end
            bus_stop();
            wq();
            // R2: stop leaves the line released
            chk(sda_o == 1'b1, "R2 released after stop", sda_o, 1);
        end
        busy = 1'b0;

        // R9: several data bytes under one address
        rx0 = rx_n;
        bus_start();
        send_byte({7'h50, 1'b0}, ak);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'h10 + 8'(i), ak);
            chk(ak == 1'b1, "R9 multi-byte ack", ak, 1);
        end
        bus_stop();
        chk(rx_n == rx0 + 3, "R9 byte count", rx_n - rx0, 3);
        chk(rx_last == 8'h12, "R9 last byte", rx_last, 8'h12);

        // R6/R7: two-byte read, ack then not-ack
        tx0 = tx_n;
        txb = 8'hC3;
        bus_start();
        send_byte({7'h50, 1'b1}, ak);
        chk(ak == 1'b1, "R6 read address ack", ak, 1);
        wq();
        txb = 8'h5A;
        recv_byte(1'b1, v);
        chk(v == 8'hC3, "R6 first read byte", v, 8'hC3);
        recv_byte(1'b0, v);
        chk(v == 8'h5A, "R6 second read byte", v, 8'h5A);
        chk(tx_n == tx0 + 2, "R6 tx_load count", tx_n - tx0, 2);
        clk_bit(1'b1, r);
        chk(r == 1'b1, "R7 released after not-ack", r, 1);
        chk(tx_n == tx0 + 2, "R7 no load after not-ack", tx_n - tx0, 2);
        bus_stop();

        // R10: repeated start in the middle of a byte
        rx0 = rx_n;
        txb = 8'h96;
        bus_start();
        send_byte({7'h50, 1'b0}, ak);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
        bus_start();
        send_byte({7'h50, 1'b1}, ak);
        chk(ak == 1'b1, "R10 new address acked", ak, 1);
        recv_byte(1'b0, v);
        chk(v == 8'h96, "R10 read after restart", v, 8'h96);
        chk(rx_n == rx0, "R10 partial byte dropped", rx_n - rx0, 0);
        bus_stop();

        // R5: busy rises between address and data
        rx0 = rx_n;
        bus_start();
        send_byte({7'h50, 1'b0}, ak);
        chk(ak == 1'b1, "R5 address ack while idle", ak, 1);
        busy = 1'b1;
        send_byte(8'h44, ak);
        chk(ak == 1'b0, "R5 data not acked while busy", ak, 0);
        chk(rx_n == rx0, "R5 no rx_valid while busy", rx_n - rx0, 0);
        busy = 1'b0;
        bus_stop();

        // R2/R1: stop mid-byte, then a normal write
        bus_start();
        send_byte({7'h50, 1'b0}, ak);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, r);
        bus_stop();
        chk(sda_o == 1'b1, "R2 stop mid-byte releases", sda_o, 1);
        rx0 = rx_n;
        bus_start();
        send_byte({7'h50, 1'b0}, ak);
        chk(ak == 1'b1, "R1 address after stop", ak, 1);
        send_byte(8'h11, ak);
        chk(ak == 1'b1 && rx_last == 8'h11, "R1 write after stop", rx_last, 8'h11);
        bus_stop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule